// File: doc/BRIEF.md
# DS1 Receive Payload Timing Generator

This block produces the receive-side timing strobes for a serial DS1 payload stream when the slip buffer is bypassed. All logic runs on the recovered receive line clock, one clock per DS1 bit. A single bit-position counter and a frame counter track where the current bit sits in the 193-bit frame and in the superframe. The strobes are decoded from those two counters. They are a time-slot indicator clock, the time-slot number, a pulse at the end of each frame and a pulse at the end of each superframe.

A fractional mode lets the terminal equipment take only a chosen subset of the 24 time slots. In that mode the time-slot clock pin becomes either a gapped clock or a clock enable. The three low time-slot number pins then carry the fractional data, the robbed-bit signalling bit and a fractional slot indicator. A frame-alignment input from the upstream alignment logic restarts the counters.

Top module: `ds1_rx_timing`

## Requirements
- R1: The bit counter runs through positions 0 to 192. The frame counter runs 0 to 11 when `sf_long`=0 and 0 to 23 when `sf_long`=1. Reset, or `frame_align` high in a cycle, puts the next cycle at bit 0 of frame 0.
- R2: With `frac_en`=0, `ts_clk` is high exactly in the cycles at bit positions 8, 16, ..., 192, which are the LSBs of slots 0 to 23. It is low in every other cycle.
- R3: With `frac_en`=0, `ts_pins` gives the slot number. Slot k covers bit positions 8k+1 to 8k+8, MSB first. At the framing bit (position 0) the value is 0.
- R4: `frame_sync` is high only at bit position 192 of every frame.
- R5: `mframe_sync` is high only at bit position 192 of the last frame: frame 11 when `sf_long`=0, frame 23 when `sf_long`=1.
- R6: With `frac_en`=1 and `frac_ce_mode`=1, `ts_clk` is a level clock enable. It is high for every bit of slot k when `frac_mask[k]`=1, and low otherwise, including at the framing bit.
- R7: With `frac_en`=1 and `frac_ce_mode`=0, `ts_clk` is a gapped clock. During enabled slot bits it equals `clk`; otherwise it stays low in both clock phases.
- R8: With `frac_en`=1, `ts_pins[0]` equals `rx_data` during the bits of enabled slots and is 0 otherwise.
- R9: With `frac_en`=1, `ts_pins[1]` equals `rx_data` at the LSB of any slot in frames whose index mod 6 equals 5. These are the signalling frames 5, 11, 17 and 23. It is 0 otherwise, whatever the mask.
- R10: With `frac_en`=1, `ts_pins[2]` is high during the bits of enabled slots. `ts_pins[4:3]` keep slot number bits 4:3.
- R11: `sync_out_en` is 1 when `slip_cfg` is 2'b00 or 2'b11 (bypass) and 0 for 2'b01 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive line clock, one cycle per DS1 bit |
| rst | input | 1 | Synchronous active-high reset |
| frame_align | input | 1 | Next cycle is the framing bit of frame 0 |
| sf_long | input | 1 | Superframe length: 0 = 12 frames, 1 = 24 frames |
| slip_cfg | input | 2 | Slip buffer setting; 00 or 11 means bypass |
| rx_data | input | 1 | Incoming serial payload bit |
| frac_en | input | 1 | Fractional output mode enable |
| frac_ce_mode | input | 1 | In fractional mode: 1 = clock enable, 0 = gapped clock |
| frac_mask | input | 24 | Per-slot fractional enable, bit k for slot k |
| ts_clk | output | 1 | Time-slot clock, gapped clock or clock enable |
| ts_pins | output | 5 | Slot number, or fractional data/signalling/indicator on bits 2:0 |
| frame_sync | output | 1 | End-of-frame pulse |
| mframe_sync | output | 1 | End-of-superframe pulse |
| sync_out_en | output | 1 | Frame sync pin drive enable in bypass mode |

## Verification
The bench targets the off-by-one edges of the frame. If the slot decode is shifted by one bit, the slot number changes one cycle early, and a design that strobed the wrong end of a slot would pulse `ts_clk` on MSBs. Both superframe lengths are run across their wrap, so a multiframe counter with the wrong limit misplaces `mframe_sync`. A mid-frame alignment pulse shows whether the restart reaches both counters. The fractional runs use sparse masks and a mask with mixed edges, and they sample the gapped clock in both phases. A design that ignored the mask, leaked data outside enabled slots, or ran the clock while gapped would show up there, as would signalling taken in the wrong frames.

// File: rtl/ds1_rx_pkg.sv
package ds1_rx_pkg;

    localparam int FRAME_BITS  = 193;
    localparam int SLOT_COUNT  = 24;
    localparam int SLOT_LEN    = 8;
    localparam int SF_FRAMES   = 12;
    localparam int ESF_FRAMES  = 24;
    localparam int SIG_PERIOD  = 6;

    localparam int POS_W   = $clog2(FRAME_BITS);
    localparam int SLOT_W  = $clog2(SLOT_COUNT);
    localparam int FRAME_W = $clog2(ESF_FRAMES);

    typedef logic [POS_W-1:0]   bitpos_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [SLOT_W-1:0]  slot_t;

    typedef enum logic {
        SF_SHORT = 1'b0,
        SF_LONG  = 1'b1
    } sf_len_e;

    typedef struct packed {
        frame_t  frame;
        bitpos_t bitpos;
    } pos_t;

    typedef struct packed {
        slot_t num;
        logic  framing;
        logic  lsb;
        logic  hit;
        logic  sig_frame;
    } slot_info_t;

    localparam bitpos_t LAST_BIT = bitpos_t'(FRAME_BITS - 1);

    function automatic frame_t last_frame(sf_len_e len);
        return (len == SF_LONG) ? frame_t'(ESF_FRAMES - 1) : frame_t'(SF_FRAMES - 1);
    endfunction

    function automatic logic is_bypass(logic [1:0] cfg);
        return cfg[1] == cfg[0];
    endfunction

endpackage

// File: rtl/ds1_pos_counter.sv
module ds1_pos_counter
    import ds1_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    align,
    input  sf_len_e sf_len,
    output pos_t    pos
);

    frame_t frame_lim;
    assign frame_lim = last_frame(sf_len);

    always_ff @(posedge clk) begin
        if (rst || align) begin
            pos <= '0;
        end else if (pos.bitpos == LAST_BIT) begin
            pos.bitpos <= '0;
            pos.frame  <= (pos.frame >= frame_lim) ? '0 : pos.frame + 1'b1;
        end else begin
            pos.bitpos <= pos.bitpos + 1'b1;
        end
    end

    // R1: an alignment pulse restarts both counters
    p_align_restart_r1: assert property (@(posedge clk) disable iff (rst)
        align |=> (pos.bitpos == '0 && pos.frame == '0));

    // R1: inside a frame the bit position advances by one
    p_bit_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!align && pos.bitpos != LAST_BIT) |=> (pos.bitpos == $past(pos.bitpos) + 1'b1));

    // R1: the last bit wraps to the framing bit and the frame index moves
    p_frame_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (!align && pos.bitpos == LAST_BIT) |=> (pos.bitpos == '0 && pos.frame != $past(pos.frame)));

endmodule

// File: rtl/ds1_slot_decode.sv
module ds1_slot_decode
    import ds1_rx_pkg::*;
(
    input  pos_t                  pos,
    input  logic [SLOT_COUNT-1:0] mask,
    output slot_info_t            info
);

    bitpos_t               off;
    slot_t                 num;
    logic                  framing;
    logic [SLOT_COUNT-1:0] hit_vec;

    assign framing = (pos.bitpos == '0);
    assign off     = pos.bitpos - 1'b1;
    assign num     = framing ? '0 : slot_t'(off / bitpos_t'(SLOT_LEN));

    for (genvar k = 0; k < SLOT_COUNT; k++) begin : g_slot_hit
        assign hit_vec[k] = mask[k] && !framing && (num == slot_t'(k));
    end

    always_comb begin
        info.num       = num;
        info.framing   = framing;
        info.lsb       = !framing && ((off % bitpos_t'(SLOT_LEN)) == bitpos_t'(SLOT_LEN - 1));
        info.hit       = |hit_vec;
        info.sig_frame = (pos.frame % frame_t'(SIG_PERIOD)) == frame_t'(SIG_PERIOD - 1);
    end

endmodule

// File: rtl/ds1_rx_timing.sv
module ds1_rx_timing
    import ds1_rx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_align,
    input  logic                  sf_long,
    input  logic [1:0]            slip_cfg,
    input  logic                  rx_data,
    input  logic                  frac_en,
    input  logic                  frac_ce_mode,
    input  logic [SLOT_COUNT-1:0] frac_mask,
    output logic                  ts_clk,
    output logic [SLOT_W-1:0]     ts_pins,
    output logic                  frame_sync,
    output logic                  mframe_sync,
    output logic                  sync_out_en
);

    sf_len_e    sf_len;
    pos_t       pos;
    slot_info_t info;
    logic       frac_bit;
    logic       sig_bit;

    assign sf_len = sf_len_e'(sf_long);

    ds1_pos_counter u_pos (
        .clk    (clk),
        .rst    (rst),
        .align  (frame_align),
        .sf_len (sf_len),
        .pos    (pos)
    );

    ds1_slot_decode u_dec (
        .pos  (pos),
        .mask (frac_mask),
        .info (info)
    );

    assign frame_sync  = (pos.bitpos == LAST_BIT);
    assign mframe_sync = frame_sync && (pos.frame == last_frame(sf_len));
    assign sync_out_en = is_bypass(slip_cfg);

    assign frac_bit = rx_data & info.hit;
    assign sig_bit  = rx_data & info.lsb & info.sig_frame;

    always_comb begin
        if (frac_en) begin
            ts_pins = {info.num[SLOT_W-1:3], info.hit, sig_bit, frac_bit};
            ts_clk  = frac_ce_mode ? info.hit : (info.hit & clk);
        end else begin
            ts_pins = info.num;
            ts_clk  = info.lsb;
        end
    end

    // R5: the superframe pulse only comes with a frame pulse
    p_mframe_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
        mframe_sync |-> frame_sync);

    // R4: the frame pulse lasts one bit period
    p_frame_pulse_once_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && !frame_align) |=> !frame_sync);

    // R8: no fractional data outside an enabled slot
    p_frac_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (frac_en && !ts_pins[2]) |-> !ts_pins[0]);

    // R2: in normal mode the slot strobe is never two bits wide
    p_slot_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
        (!frac_en && ts_clk) |=> (!ts_clk || frac_en));

endmodule

// File: tb/ds1_rx_timing_tb.sv
module ds1_rx_timing_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_align = 1'b0;
    logic        sf_long = 1'b0;
    logic [1:0]  slip_cfg = 2'b00;
    logic        rx_data = 1'b0;
    logic        frac_en = 1'b0;
    logic        frac_ce_mode = 1'b0;
    logic [23:0] frac_mask = '0;
    logic        ts_clk;
    logic [4:0]  ts_pins;
    logic        frame_sync;
    logic        mframe_sync;
    logic        sync_out_en;

    always #(CLK_P/2) clk = ~clk;

    ds1_rx_timing dut_i (
        .clk          (clk),
        .rst          (rst),
        .frame_align  (frame_align),
        .sf_long      (sf_long),
        .slip_cfg     (slip_cfg),
        .rx_data      (rx_data),
        .frac_en      (frac_en),
        .frac_ce_mode (frac_ce_mode),
        .frac_mask    (frac_mask),
        .ts_clk       (ts_clk),
        .ts_pins      (ts_pins),
        .frame_sync   (frame_sync),
        .mframe_sync  (mframe_sync),
        .sync_out_en  (sync_out_en)
    );

    typedef struct {
        logic       ts_hi;
        logic       ts_lo;
        logic [4:0] pins;
        logic       fs;
        logic       mfs;
        logic       oe;
        logic       frac;
        logic       ce;
        int         b;
        int         f;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad   = 0;
    int mb    = 0;
    int mf    = 0;
    bit done  = 0;

    logic        n_sf_long = 1'b0;
    logic [1:0]  n_slip    = 2'b00;
    logic        n_frac    = 1'b0;
    logic        n_ce      = 1'b0;
    logic [23:0] n_mask    = '0;

    task automatic chk(input string req, input int act, input int exp, input int b, input int f);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s bit=%0d frame=%0d actual=%0d expected=%0d", req, b, f, act, exp);
        end
    endtask

    // driver: applies inputs for one cycle and queues what the outputs must show
    task automatic step(input logic r, input logic a);
        exp_t e;
        int   slot;
        logic lsb, act, sig, d;
        int   nfr;
        @(posedge clk);
        #1;
        rst          = r;
        frame_align  = a;
        sf_long      = n_sf_long;
        slip_cfg     = n_slip;
        frac_en      = n_frac;
        frac_ce_mode = n_ce;
        frac_mask    = n_mask;
        d            = 1'($urandom);
        rx_data      = d;
        slot = (mb == 0) ? 0 : (mb - 1) / 8;
        lsb  = (mb != 0) && (mb % 8 == 0);
        act  = n_frac && (mb != 0) && n_mask[slot];
        sig  = (lsb && (mf % 6 == 5)) ? d : 1'b0;
        e.frac = n_frac;
        e.ce   = n_ce;
        e.b    = mb;
        e.f    = mf;
        e.pins = n_frac ? {slot[4:3], act, sig, d & act} : slot[4:0];
        e.ts_hi = n_frac ? act : lsb;
        e.ts_lo = n_frac ? (n_ce ? act : 1'b0) : lsb;
        e.fs  = (mb == 192);
        nfr   = n_sf_long ? 24 : 12;
        e.mfs = (mb == 192) && (mf == nfr - 1);
        e.oe  = (n_slip == 2'b00) || (n_slip == 2'b11);
        q.push_back(e);
        // R1: model of the position for the next cycle
        if (r || a) begin
            mb = 0;
            mf = 0;
        end else if (mb == 192) begin
            mb = 0;
            mf = (mf >= nfr - 1) ? 0 : mf + 1;
        end else begin
            mb++;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    // monitor: compares each queued item in the high and the low clock phase
    always @(posedge clk) begin
        exp_t e;
        #3;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk(e.frac ? (e.ce ? "R6 ts_clk enable" : "R7 ts_clk gapped high") : "R2 ts_clk strobe",
                int'(ts_clk), int'(e.ts_hi), e.b, e.f);
            chk(e.frac ? "R8/R9/R10 ts_pins fractional" : "R3 ts_pins slot number",
                int'(ts_pins), int'(e.pins), e.b, e.f);
            chk("R4 frame_sync", int'(frame_sync), int'(e.fs), e.b, e.f);
            chk("R5 mframe_sync", int'(mframe_sync), int'(e.mfs), e.b, e.f);
            chk("R11 sync_out_en", int'(sync_out_en), int'(e.oe), e.b, e.f);
            #4;
            chk(e.frac ? (e.ce ? "R6 ts_clk enable low phase" : "R7 ts_clk gapped low phase")
                       : "R2 ts_clk low phase",
                int'(ts_clk), int'(e.ts_lo), e.b, e.f);
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        @(posedge clk);
        // reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        // R2 R3 R4 R5: normal mode, 12-frame superframe across its wrap
        run(12 * 193 + 60);
        // R1: realignment in the middle of a frame
        run(37);
        step(1'b0, 1'b1);
        run(420);
        // R5: 24-frame superframe, non-bypass slip setting for R11
        n_sf_long = 1'b1;
        n_slip    = 2'b01;
        step(1'b1, 1'b0);
        run(24 * 193 + 20);
        // R6 R8 R9 R10: fractional, clock-enable form, sparse mask
        n_sf_long = 1'b0;
        n_slip    = 2'b11;
        n_frac    = 1'b1;
        n_ce      = 1'b1;
        n_mask    = 24'hA53C81;
        step(1'b1, 1'b0);
        run(7 * 193);
        // R7 R8: gapped clock, mask covering both ends of the frame
        n_ce   = 1'b0;
        n_slip = 2'b10;
        n_mask = 24'hFFF00F;
        run(2 * 193);
        // R9: no slots enabled, signalling still present in frame 11
        n_mask = 24'h000000;
        n_slip = 2'b00;
        run(6 * 193);
        // back to normal mode without reset
        n_frac = 1'b0;
        run(200);
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule